// File: doc/BRIEF.md
# Converter Serial Command and Readout Port

This block is the serial slave port that sits between a host controller and the conversion core of a delta-sigma converter. The host drives a serial clock, a chip select and a data input. The port returns data on a serial output that has its own output enable. The port runs on the system clock. It synchronises the three host pins and acts on the edges of the serial clock. Input data is taken on the rising edge and output data changes on the falling edge.

After reset the port is in command mode and waits for a valid command byte. A run command passes its decoded fields to the core and puts the port in data mode. In data mode the serial output is normally high. It drops low when the core reports a finished result. The host then clocks 32 bits: a status byte whose first bit is the low flag, followed by the 24-bit result. The host must hold its data input low during the first byte of a read. A non-zero byte in that position ends the read and is handled as a command. A power-save command returns the port to command mode. A run of at least seven all-ones bytes, followed by the byte that differs only in its last bit, also returns the port to command mode, from any state.

Top module: `adcp_serial_port`

## Requirements
- R1: After reset the port is in command mode. The serial output is high, standby is 0 and no strobe has fired. The output enable is high while chip select is low.
- R2: The command byte is sent MSB first. Bit 7 must be 1 to execute, bit 6 selects the channel, bit 5 requests power save, bit 4 selects unipolar, bits 3:2 select the filter and bits 1:0 select the calibration. A byte with bit 7 = 1 and bit 5 = 0 pulses `cmd_start` for one cycle, updates the field outputs and puts the port in data mode.
- R3: In command mode a byte with bit 7 = 0 is ignored. No strobe fires, the port stays in command mode, and a finished result does not pull the serial output low.
- R4: In data mode a finished result pulls the serial output low. A 32-clock read then returns the bits 0,1,1,1,1,channel,over-range,overflow followed by the 24-bit result, MSB first. The serial output returns high after the 32nd falling edge.
- R5: A non-zero first byte during a read ends the read and the serial output goes high. If the byte is a valid run command, it is executed as in R2.
- R6: A byte with bit 7 = 1 and bit 5 = 1 pulses `pwr_save` and returns the port to command mode. In that byte, bit 4 = 1 selects standby (`pwr_standby` = 1) and bit 4 = 0 selects sleep.
- R7: Seven or more 0xFF bytes followed by 0xFE put the port in command mode and fire no strobe. The bytes 0xFF and 0xFE are never executed as commands, so fewer than seven 0xFF bytes leave the mode unchanged.
- R8: A `conv_warn` pulse while an unread result is waiting drives the serial output high. The next `conv_done` pulls it low again with the new result.
- R9: While chip select is high the output enable is low and serial clock edges are ignored. A read does not advance while chip select is high.
- R10: A `conv_done` that arrives during a read is dropped. The read returns the earlier result, and the output stays high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data and end-of-conversion flag to host |
| sdo_oe | output | 1 | Output enable for sdo (low means high impedance) |
| conv_warn | input | 1 | Core pulse, one cycle before a result completes |
| conv_done | input | 1 | Core pulse, a result is ready |
| conv_data | input | DATA_W | Result word, valid with conv_done |
| conv_od | input | 1 | Over-range flag, valid with conv_done |
| conv_of | input | 1 | Overflow flag, valid with conv_done |
| cmd_start | output | 1 | One-cycle strobe for a run command |
| cmd_chan | output | 1 | Selected channel |
| cmd_unipolar | output | 1 | Unipolar conversion selected |
| cmd_filter | output | 2 | Filter select |
| cmd_cal | output | 2 | Calibration select |
| pwr_save | output | 1 | One-cycle strobe for a power-save command |
| pwr_standby | output | 1 | 1 for standby, 0 for sleep, set by the last power-save command |

## Verification
The hardest cases to reach are events that line up with a read already in progress. One is a core result landing in the middle of the 32 read clocks. The other is a warning pulse while a result waits unread. The bench places the core pulses from inside its read task at a chosen bit index, or between two bytes. It then proves from the serial data alone which result was delivered. The sync sequence is tested with a short run of 0xFF bytes that must not count and with a full run that must. The mode is then inferred from whether a following result pulls the serial output low.

// File: rtl/adcp_pkg.sv
package adcp_pkg;

    localparam int CMD_W    = 8;
    localparam int STATUS_W = 8;
    localparam logic [CMD_W-1:0] SYNC_FILL = 8'hFF;
    localparam logic [CMD_W-1:0] SYNC_END  = 8'hFE;

    typedef enum logic [1:0] {
        M_CMD   = 2'd0,   // waiting for a command byte
        M_WAIT  = 2'd1,   // data mode, no result pending
        M_READY = 2'd2,   // data mode, result pending, sdo low
        M_READ  = 2'd3    // data mode, result being shifted out
    } port_mode_e;

    typedef enum logic [1:0] {
        K_NULL     = 2'd0,
        K_RUN      = 2'd1,
        K_SAVE     = 2'd2,
        K_RESERVED = 2'd3
    } byte_kind_e;

    typedef struct packed {
        logic       exec;
        logic       chan;
        logic       save;
        logic       unipolar;
        logic [1:0] filt;
        logic [1:0] cal;
    } cmd_byte_t;

    function automatic byte_kind_e classify(input logic [CMD_W-1:0] b);
        cmd_byte_t c;
        c = cmd_byte_t'(b);
        if (b == '0)
            return K_NULL;
        else if (b == SYNC_FILL || b == SYNC_END || !c.exec)
            return K_RESERVED;
        else if (c.save)
            return K_SAVE;
        else
            return K_RUN;
    endfunction

    function automatic logic [STATUS_W-1:0] status_byte(input logic chan,
                                                         input logic od,
                                                         input logic ovf);
        return {1'b0, 4'b1111, chan, od, ovf};
    endfunction

endpackage

// File: rtl/adcp_pin_sync.sv
module adcp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sdi,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s
);
    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] sdi_q;
    logic [STAGES-1:0] csn_q;
    logic              sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= '0;
            sdi_q     <= '0;
            csn_q     <= '1;
            sclk_prev <= 1'b0;
        end else begin
            sclk_q    <= {sclk_q[STAGES-2:0], sclk};
            sdi_q     <= {sdi_q[STAGES-2:0], sdi};
            csn_q     <= {csn_q[STAGES-2:0], cs_n};
            sclk_prev <= sclk_q[STAGES-1];
        end
    end

    // Edges only count while the synchronised select is active.
    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev & ~csn_q[STAGES-1];
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev & ~csn_q[STAGES-1];
    assign sdi_s     = sdi_q[STAGES-1];

endmodule

// File: rtl/adcp_byte_rx.sv
module adcp_byte_rx import adcp_pkg::*; #(
    parameter int SYNC_MIN = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_val,
    output logic             byte_done,
    output logic [CMD_W-1:0] byte_val,
    output logic             sync_hit
);
    localparam int FC_W = $clog2(SYNC_MIN + 1);
    localparam logic [FC_W-1:0] FILL_MAX = FC_W'(SYNC_MIN);
    localparam int BC_W = $clog2(CMD_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(CMD_W - 1);

    logic [CMD_W-2:0] shreg;
    logic [BC_W-1:0]  bit_cnt;
    logic [FC_W-1:0]  fill_cnt;
    logic [CMD_W-1:0] full;

    assign full = {shreg, bit_val};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            fill_cnt  <= '0;
            byte_val  <= '0;
            byte_done <= 1'b0;
            sync_hit  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            sync_hit  <= 1'b0;
            if (bit_en) begin
                shreg <= full[CMD_W-2:0];
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt   <= '0;
                    byte_val  <= full;
                    byte_done <= 1'b1;
                    sync_hit  <= (full == SYNC_END) && (fill_cnt >= FILL_MAX);
                    if (full == SYNC_FILL)
                        fill_cnt <= (fill_cnt == FILL_MAX) ? fill_cnt : fill_cnt + 1'b1;
                    else
                        fill_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adcp_result_tx.sv
module adcp_result_tx #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               shift,
    output logic               top_bit,
    output logic               last_shift
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '1;
            cnt   <= '0;
        end else if (load) begin
            frame <= load_word;
            cnt   <= '0;
        end else if (shift) begin
            frame <= {frame[FRAME_W-2:0], 1'b1};
            cnt   <= cnt + 1'b1;
        end
    end

    assign top_bit    = frame[FRAME_W-1];
    assign last_shift = shift && (cnt == LAST);

endmodule

// File: rtl/adcp_serial_port.sv
module adcp_serial_port import adcp_pkg::*; #(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int SYNC_MIN    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              conv_warn,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_od,
    input  logic              conv_of,
    output logic              cmd_start,
    output logic              cmd_chan,
    output logic              cmd_unipolar,
    output logic [1:0]        cmd_filter,
    output logic [1:0]        cmd_cal,
    output logic              pwr_save,
    output logic              pwr_standby
);
    localparam int FRAME_W = STATUS_W + DATA_W;

    port_mode_e         mode;
    logic               data_phase;
    logic               sclk_rise, sclk_fall, sdi_s;
    logic               bit_en;
    logic               byte_done, sync_hit;
    logic [CMD_W-1:0]   byte_val;
    byte_kind_e         kind;
    cmd_byte_t          cmd_c;
    logic               tx_load, tx_shift, tx_top, tx_last;
    logic [FRAME_W-1:0] tx_word;

    adcp_pin_sync #(.STAGES(SYNC_STAGES)) i_pins (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s)
    );

    // Bytes are framed everywhere except during the 24 result clocks.
    assign bit_en = sclk_rise && !(mode == M_READ && data_phase);

    adcp_byte_rx #(.SYNC_MIN(SYNC_MIN)) i_rx (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_val(sdi_s),
        .byte_done(byte_done), .byte_val(byte_val), .sync_hit(sync_hit)
    );

    assign kind     = classify(byte_val);
    assign cmd_c    = cmd_byte_t'(byte_val);
    assign tx_load  = conv_done && (mode == M_WAIT || (mode == M_READY && !sclk_rise));
    assign tx_word  = {status_byte(cmd_chan, conv_od, conv_of), conv_data};
    assign tx_shift = sclk_fall && (mode == M_READ);

    adcp_result_tx #(.FRAME_W(FRAME_W)) i_tx (
        .clk(clk), .rst(rst), .load(tx_load), .load_word(tx_word),
        .shift(tx_shift), .top_bit(tx_top), .last_shift(tx_last)
    );

    assign sdo    = (mode == M_READY || mode == M_READ) ? tx_top : 1'b1;
    assign sdo_oe = ~cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= M_CMD;
            data_phase   <= 1'b0;
            cmd_start    <= 1'b0;
            cmd_chan     <= 1'b0;
            cmd_unipolar <= 1'b0;
            cmd_filter   <= '0;
            cmd_cal      <= '0;
            pwr_save     <= 1'b0;
            pwr_standby  <= 1'b0;
        end else begin
            cmd_start <= 1'b0;
            pwr_save  <= 1'b0;

            // core events
            if (tx_load)
                mode <= M_READY;
            else if (conv_warn && mode == M_READY && !sclk_rise)
                mode <= M_WAIT;

            // first clock of a read
            if (sclk_rise && mode == M_READY)
                mode <= M_READ;

            if (tx_last) begin
                mode       <= M_WAIT;
                data_phase <= 1'b0;
            end

            // byte handling has the last word on the mode
            if (byte_done) begin
                if (sync_hit) begin
                    mode       <= M_CMD;
                    data_phase <= 1'b0;
                end else begin
                    case (kind)
                        K_RUN: begin
                            cmd_start    <= 1'b1;
                            cmd_chan     <= cmd_c.chan;
                            cmd_unipolar <= cmd_c.unipolar;
                            cmd_filter   <= cmd_c.filt;
                            cmd_cal      <= cmd_c.cal;
                            mode         <= M_WAIT;
                            data_phase   <= 1'b0;
                        end
                        K_SAVE: begin
                            pwr_save    <= 1'b1;
                            pwr_standby <= cmd_c.unipolar;
                            mode        <= M_CMD;
                            data_phase  <= 1'b0;
                        end
                        K_NULL: begin
                            if (mode == M_READ)
                                data_phase <= 1'b1;
                        end
                        default: begin
                            if (mode == M_READ)
                                mode <= M_WAIT;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/adcp_port_chk.sv
module adcp_port_chk import adcp_pkg::*; (
    input logic       clk,
    input logic       rst,
    input logic       sdo,
    input logic       cmd_start,
    input logic       pwr_save,
    input logic       conv_warn,
    input logic       conv_done,
    input logic       sclk_rise,
    input logic [1:0] mode
);
    // R2: a run command leaves the port in data mode without a result
    a_r2_start_to_data: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (mode == M_WAIT));

    // R2 / R6: one byte never fires both strobes
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(cmd_start && pwr_save));

    // R6: power save returns to command mode
    a_r6_save_to_cmd: assert property (@(posedge clk) disable iff (rst)
        pwr_save |=> (mode == M_CMD));

    // R3: command mode never shows the end-of-conversion flag
    a_r3_cmd_sdo_high: assert property (@(posedge clk) disable iff (rst)
        (mode == M_CMD) |-> sdo);

    // R4: a pending result always shows a low flag
    a_r4_ready_low: assert property (@(posedge clk) disable iff (rst)
        (mode == M_READY) |-> !sdo);

    // R8: a warning on an unread result releases the flag
    a_r8_warn_release: assert property (@(posedge clk) disable iff (rst)
        (conv_warn && !conv_done && !sclk_rise && mode == M_READY) |=> sdo);

endmodule

bind adcp_serial_port adcp_port_chk i_chk (
    .clk(clk), .rst(rst), .sdo(sdo), .cmd_start(cmd_start),
    .pwr_save(pwr_save), .conv_warn(conv_warn), .conv_done(conv_done),
    .sclk_rise(sclk_rise), .mode(mode)
);

// File: tb/test_adcp_serial_port.sv
module test_adcp_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic conv_warn = 1'b0, conv_done = 1'b0, conv_od = 1'b0, conv_of = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic cmd_start, cmd_chan, cmd_unipolar, pwr_save, pwr_standby;
    logic [1:0] cmd_filter, cmd_cal;

    int checks = 0, errors = 0, n_start = 0, n_save = 0;
    bit done = 0;
    logic exp_ch = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcp_serial_port i_adcp_serial_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .conv_warn(conv_warn), .conv_done(conv_done),
        .conv_data(conv_data), .conv_od(conv_od), .conv_of(conv_of),
        .cmd_start(cmd_start), .cmd_chan(cmd_chan), .cmd_unipolar(cmd_unipolar),
        .cmd_filter(cmd_filter), .cmd_cal(cmd_cal), .pwr_save(pwr_save),
        .pwr_standby(pwr_standby)
    );

    always @(negedge clk) begin
        if (!rst && cmd_start) n_start++;
        if (!rst && pwr_save)  n_save++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic ch, input logic od,
                                              input logic ovf, input logic [DW-1:0] d);
        return {1'b0, 4'b1111, ch, od, ovf, d};
    endfunction

    task automatic clk_bit(input logic b, output logic s);
        repeat (H) @(negedge clk);
        s = sdo;
        sdi = b;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        sdi = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic conv(input logic [DW-1:0] d, input logic od, input logic ovf);
        @(negedge clk);
        conv_data = d; conv_od = od; conv_of = ovf; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic warn();
        @(negedge clk);
        conv_warn = 1'b1;
        @(negedge clk);
        conv_warn = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_frame(input int inj, input logic [DW-1:0] inj_d, output logic [31:0] f);
        logic s;
        f = '0;
        for (int i = 0; i < 32; i++) begin
            if (i == inj) conv(inj_d, 1'b1, 1'b1);
            clk_bit(1'b0, s);
            f = {f[30:0], s};
        end
        repeat (H) @(negedge clk);
    endtask

    task automatic run_cmd(input logic [7:0] b);
        send_byte(b);
        exp_ch = b[6];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] f;
        int base;
        int seed_v;
        seed_v = $urandom(32'h5EED);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 sdo", sdo, 1);
        check("R1 oe", sdo_oe, 1);
        check("R1 standby", pwr_standby, 0);
        check("R1 strobes", n_start + n_save, 0);

        // R3 D7=0 ignored in command mode
        send_byte(8'h45);
        check("R3 no start", n_start, 0);
        conv(24'h123456, 1'b0, 1'b0);
        check("R3 still cmd mode", sdo, 1);

        // R2 run command 0xD9: ch1 uni1 filt2 cal1
        run_cmd(8'hD9);
        check("R2 start", n_start, 1);
        check("R2 fields", {cmd_chan, cmd_unipolar, cmd_filter, cmd_cal}, 6'b11_10_01);

        // R4 read
        conv(24'hA5C317, 1'b1, 1'b0);
        check("R4 flag low", sdo, 0);
        read_frame(-1, '0, f);
        check("R4 frame", f, exp_frame(exp_ch, 1'b1, 1'b0, 24'hA5C317));
        check("R4 high after", sdo, 1);

        // R8 unread result
        conv(24'h00F00D, 1'b0, 1'b1);
        warn();
        check("R8 released", sdo, 1);
        conv(24'h7E57AB, 1'b0, 1'b0);
        check("R8 low again", sdo, 0);
        read_frame(-1, '0, f);
        check("R8 frame", f, exp_frame(exp_ch, 1'b0, 1'b0, 24'h7E57AB));

        // R10 result during read dropped
        conv(24'h111111, 1'b0, 1'b0);
        read_frame(12, 24'h222222, f);
        check("R10 frame", f, exp_frame(exp_ch, 1'b0, 1'b0, 24'h111111));
        check("R10 no new flag", sdo, 1);

        // R5 non-null first byte
        conv(24'h333333, 1'b0, 1'b0);
        base = n_start;
        run_cmd(8'h84);
        check("R5 restarted", n_start, base + 1);
        check("R5 read ended", sdo, 1);
        check("R5 chan", cmd_chan, 0);

        // R9 chip select high
        conv(24'h9ABCDE, 1'b1, 1'b1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 oe low", sdo_oe, 0);
        for (int i = 0; i < 10; i++) begin
            logic s;
            clk_bit(1'b1, s);
        end
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        check("R9 flag kept", sdo, 0);
        read_frame(-1, '0, f);
        check("R9 frame intact", f, exp_frame(exp_ch, 1'b1, 1'b1, 24'h9ABCDE));

        // R7 short sync run is not a sync
        base = n_start + n_save;
        for (int i = 0; i < 6; i++) send_byte(8'hFF);
        send_byte(8'hFE);
        conv(24'h444444, 1'b0, 1'b0);
        check("R7 short run stays data", sdo, 0);
        read_frame(-1, '0, f);
        check("R7 short run frame", f, exp_frame(exp_ch, 1'b0, 1'b0, 24'h444444));
        // R7 full sync run
        for (int i = 0; i < 7; i++) send_byte(8'hFF);
        send_byte(8'hFE);
        conv(24'h555555, 1'b0, 1'b0);
        check("R7 command mode", sdo, 1);
        check("R7 no strobes", n_start + n_save, base);

        // R6 power save
        run_cmd(8'h80);
        send_byte(8'hA0);
        check("R6 save strobe", n_save, 1);
        check("R6 sleep", pwr_standby, 0);
        conv(24'h666666, 1'b0, 1'b0);
        check("R6 command mode", sdo, 1);
        send_byte(8'hB3);
        check("R6 standby", pwr_standby, 1);
        check("R6 second strobe", n_save, 2);

        // R2 / R4 random
        for (int k = 0; k < 16; k++) begin
            logic [7:0] c;
            logic [DW-1:0] d;
            logic od, ovf;
            c = {1'b1, 1'($urandom), 1'b0, 5'($urandom)};
            d = DW'($urandom);
            od = 1'($urandom);
            ovf = 1'($urandom);
            run_cmd(c);
            check("R2 random fields", {cmd_chan, cmd_unipolar, cmd_filter, cmd_cal},
                  {c[6], c[4], c[3:2], c[1:0]});
            conv(d, od, ovf);
            read_frame(-1, '0, f);
            check("R4 random frame", f, exp_frame(exp_ch, od, ovf, d));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule